// File: doc/BRIEF.md
# Connection Memory Bulk Fill Controller

This block fills every word of a switch's connection memory with one value taken from a small control register. Software writes the register once. The write sets an arm flag, a 4-bit fill pattern and a go bit together. The controller then sweeps the memory address space in ascending order. Each word receives the pattern in its top bits, and every lower bit is cleared. The sweep is paced so that the whole memory is covered within one frame period. The fill is declared finished at the second frame sync pulse after it started. At that point the controller clears the go bit, and software reads this as the completion signal.

While no fill is running, ordinary per-word host writes pass straight through to the memory write port. While a fill is running, host writes are dropped. Any write to the control register during a fill stops the fill at once. This includes clearing go or clearing arm. Words already written keep their new value.

Top module: `cmfill_ctrl`

## Requirements
- R1: Control register layout: bit 0 is go, bits 4:1 are the pattern and bit 5 is arm. A write that sets go while arm is 0 starts no fill and causes no memory write. The register simply stores the written value.
- R2: A fill starts only on a register write that has arm = 1 and go = 1 while the stored go bit is 0. Writing go = 1 over a stored go = 1 starts nothing.
- R3: The fill pattern is the pattern field of the same write that starts the fill.
- R4: A fill writes addresses 0 up to DEPTH-1 in ascending order, one word every STRIDE = FRAME_CYCLES/DEPTH cycles. The first word is written STRIDE cycles after the starting write. Each word holds the pattern in bits 15:12, and bits 11:0 are zero.
- R5: The fill completes on the second frame sync pulse after the starting write. A sync in the same cycle as the starting write is not counted. Completion clears go and keeps arm and the pattern.
- R6: A register write during a fill that clears go or clears arm aborts the fill. No further fill writes occur, and the register takes the written value.
- R7: Any other register write during a fill also aborts it. Words written before the abort keep their values.
- R8: When a register write lands in the same cycle as the completing frame sync, the write wins. The register takes the written value, go is not cleared, and no new fill starts.
- R9: While idle, a host write appears on the memory write port in the same cycle, with its address and data unchanged.
- R10: During a fill, host writes never reach the memory port.
- R11: After reset, the control register reads 0 and no memory write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 6 | Control register write value (go, pattern, arm) |
| reg_rdata | output | 6 | Current control register value |
| frame_sync | input | 1 | One-cycle frame start pulse |
| host_we | input | 1 | Host per-word memory write strobe |
| host_addr | input | 6 | Host write address |
| host_wdata | input | 16 | Host write data |
| cm_we | output | 1 | Connection memory write strobe |
| cm_addr | output | 6 | Connection memory write address |
| cm_wdata | output | 16 | Connection memory write data |

## Verification
Two functions can meet in one cycle: completion, triggered by the second frame sync, and the abort or load caused by a register write. The bench provokes this by issuing a control write in exactly the cycle that carries the completing sync. It then checks that the register holds the written value with go still set, and that no fill write follows. A second pairing is also exercised: a frame sync in the same cycle as the starting write must not count toward completion. Here the bench confirms that go survives the next sync and falls only on the one after.

// File: rtl/cmfill_pkg.sv
package cmfill_pkg;
   // bit position of the go flag inside the control word
   localparam int unsigned GO_POS  = 0;
   // lowest bit of the pattern field
   localparam int unsigned PAT_LSB = 1;

   typedef enum logic [0:0] {
      FILL_IDLE = 1'b0,
      FILL_RUN  = 1'b1
   } fill_state_e;
endpackage

// File: rtl/cmfill_ctlreg.sv
module cmfill_ctlreg
   import cmfill_pkg::*;
#(
   parameter int unsigned PAT_W = 4,
   localparam int unsigned CTL_W  = PAT_W + 2,
   localparam int unsigned ARM_POS = PAT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [CTL_W-1:0] reg_wdata,
   input  logic             done_clr,
   output logic [CTL_W-1:0] ctl_q,
   output logic             start_req
);
   // a start needs arm in the written word and a 0->1 move of go
   assign start_req = reg_wr && reg_wdata[ARM_POS] && reg_wdata[GO_POS]
                      && !ctl_q[GO_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (reg_wr) begin
         ctl_q <= reg_wdata;              // a host write always wins (R8)
      end else if (done_clr) begin
         ctl_q[GO_POS] <= 1'b0;           // completion report (R5)
      end
   end
endmodule

// File: rtl/cmfill_sweep.sv
module cmfill_sweep
   import cmfill_pkg::*;
#(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned STRIDE = 4,
   localparam int unsigned ADDR_W = $clog2(DEPTH),
   localparam int unsigned PACE_W = (STRIDE > 1) ? $clog2(STRIDE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              frame_sync,
   output logic              running,
   output logic              fill_we,
   output logic [ADDR_W-1:0] fill_addr,
   output logic              done
);
   fill_state_e state_q;
   logic        sync_seen_q;
   logic        swept_q;
   logic        pace_hit;

   assign running = (state_q == FILL_RUN);
   assign fill_we = running && !swept_q && pace_hit;
   assign done    = running && frame_sync && sync_seen_q && !abort;

   generate
      if (STRIDE == 1) begin : g_no_pace
         assign pace_hit = 1'b1;
      end else begin : g_pace
         logic [PACE_W-1:0] pace_q;
         assign pace_hit = (pace_q == PACE_W'(STRIDE - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            pace_q <= '0;
            else if (start)        pace_q <= '0;
            else if (running)      pace_q <= pace_hit ? '0 : pace_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= FILL_IDLE;
         sync_seen_q <= 1'b0;
         swept_q     <= 1'b0;
         fill_addr   <= '0;
      end else if (start) begin
         state_q     <= FILL_RUN;     // sync in this cycle is not counted
         sync_seen_q <= 1'b0;
         swept_q     <= 1'b0;
         fill_addr   <= '0;
      end else if (running) begin
         if (abort || done) begin
            state_q <= FILL_IDLE;
         end else begin
            if (frame_sync) sync_seen_q <= 1'b1;
            if (fill_we) begin
               if (fill_addr == ADDR_W'(DEPTH - 1)) swept_q   <= 1'b1;
               else                                 fill_addr <= fill_addr + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cmfill_ctrl.sv
module cmfill_ctrl
   import cmfill_pkg::*;
#(
   parameter int unsigned CM_W         = 16,
   parameter int unsigned PAT_W        = 4,
   parameter int unsigned DEPTH        = 64,
   parameter int unsigned FRAME_CYCLES = 256,
   localparam int unsigned ADDR_W = $clog2(DEPTH),
   localparam int unsigned CTL_W  = PAT_W + 2,
   localparam int unsigned LOW_W  = CM_W - PAT_W,
   localparam int unsigned STRIDE = FRAME_CYCLES / DEPTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [CTL_W-1:0]  reg_wdata,
   output logic [CTL_W-1:0]  reg_rdata,
   input  logic              frame_sync,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [CM_W-1:0]   host_wdata,
   output logic              cm_we,
   output logic [ADDR_W-1:0] cm_addr,
   output logic [CM_W-1:0]   cm_wdata
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cmfill_ctrl: DEPTH must be at least 2");
      end
      if (PAT_W >= CM_W) begin : g_bad_pat
         $error("cmfill_ctrl: PAT_W must be narrower than CM_W");
      end
      if (STRIDE < 1) begin : g_bad_frame
         $error("cmfill_ctrl: FRAME_CYCLES must cover DEPTH writes");
      end
   endgenerate

   logic              start_w;
   logic              done_w;
   logic              run_w;
   logic              fill_we;
   logic [ADDR_W-1:0] fill_addr;
   logic [CM_W-1:0]   fill_word;

   cmfill_ctlreg #(.PAT_W(PAT_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .done_clr  (done_w),
      .ctl_q     (reg_rdata),
      .start_req (start_w)
   );

   cmfill_sweep #(.DEPTH(DEPTH), .STRIDE(STRIDE)) u_sweep (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_w),
      .abort      (reg_wr),
      .frame_sync (frame_sync),
      .running    (run_w),
      .fill_we    (fill_we),
      .fill_addr  (fill_addr),
      .done       (done_w)
   );

   assign fill_word = {reg_rdata[PAT_LSB +: PAT_W], {LOW_W{1'b0}}};

   // host path is shut off for the whole fill
   assign cm_we    = run_w ? fill_we   : host_we;
   assign cm_addr  = run_w ? fill_addr : host_addr;
   assign cm_wdata = run_w ? fill_word : host_wdata;
endmodule

// File: rtl/cmfill_ctrl_chk.sv
module cmfill_ctrl_chk #(
   parameter int unsigned CM_W  = 16,
   parameter int unsigned PAT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             wr_arm,
   input logic             rd_go,
   input logic [PAT_W-1:0] rd_pat,
   input logic             frame_sync,
   input logic             host_we,
   input logic             cm_we,
   input logic [CM_W-1:0]  cm_wdata,
   input logic             fill_run
);
   p_arm_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fill_run) |-> $past(reg_wr && wr_arm));

   p_go_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fill_run) |-> !$past(rd_go));

   p_fill_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_run && cm_we) |-> (cm_wdata == {rd_pat, {(CM_W-PAT_W){1'b0}}}));

   p_done_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(fill_run) && !$past(reg_wr)) |-> ($past(frame_sync) && !rd_go));

   // covers R6 as well: clearing go or arm is itself a register write
   p_wr_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_run && reg_wr) |=> !fill_run);

   p_idle_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_run |-> (cm_we == host_we));
endmodule

bind cmfill_ctrl cmfill_ctrl_chk #(.CM_W(CM_W), .PAT_W(PAT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .wr_arm     (reg_wdata[PAT_W+1]),
   .rd_go      (reg_rdata[0]),
   .rd_pat     (reg_rdata[PAT_W:1]),
   .frame_sync (frame_sync),
   .host_we    (host_we),
   .cm_we      (cm_we),
   .cm_wdata   (cm_wdata),
   .fill_run   (run_w)
);

// File: tb/cmfill_ctrl_tb.sv
`timescale 1ns/1ps
module cmfill_ctrl_tb;
   localparam int CM_W = 16;
   localparam int PAT_W = 4;
   localparam int DEPTH = 64;
   localparam int FRAME = 256;
   localparam int CTL_W = PAT_W + 2;
   localparam int AW = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic [CTL_W-1:0] reg_wdata = '0;
   logic [CTL_W-1:0] reg_rdata;
   logic             frame_sync = 1'b0;
   logic             host_we = 1'b0;
   logic [AW-1:0]    host_addr = '0;
   logic [CM_W-1:0]  host_wdata = '0;
   logic             cm_we;
   logic [AW-1:0]    cm_addr;
   logic [CM_W-1:0]  cm_wdata;

   int total = 0;
   int bad = 0;

   logic [AW-1:0]   q_addr[$];
   logic [CM_W-1:0] q_data[$];
   string           q_tag[$];

   always #10 clk = ~clk;

   cmfill_ctrl #(.CM_W(CM_W), .PAT_W(PAT_W), .DEPTH(DEPTH), .FRAME_CYCLES(FRAME)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .frame_sync(frame_sync), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .cm_we(cm_we),
      .cm_addr(cm_addr), .cm_wdata(cm_wdata));

   function automatic logic [CTL_W-1:0] ctl(input logic arm, input logic [3:0] pat, input logic go);
      return {arm, pat, go};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic wr_ctl(input logic [CTL_W-1:0] v, input logic s);
      reg_wr = 1'b1; reg_wdata = v; frame_sync = s;
      cyc();
      reg_wr = 1'b0; frame_sync = 1'b0;
   endtask

   task automatic pulse_sync();
      frame_sync = 1'b1;
      cyc();
      frame_sync = 1'b0;
   endtask

   task automatic push(input logic [AW-1:0] a, input logic [CM_W-1:0] d, input string tag);
      q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
   endtask

   task automatic push_fill(input logic [3:0] pat, input int n, input string tag);
      for (int k = 0; k < n; k++) push(AW'(k), {pat, 12'h000}, tag);
   endtask

   // monitor: every memory write must match the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && cm_we) begin
         total++;
         if (q_addr.size() == 0) begin
            bad++;
            $display("FAIL unexpected write (R1/R2/R6/R7/R8/R10): actual=%h:%h expected=none",
                     cm_addr, cm_wdata);
         end else begin
            logic [AW-1:0] ea;
            logic [CM_W-1:0] ed;
            string t;
            ea = q_addr.pop_front(); ed = q_data.pop_front(); t = q_tag.pop_front();
            if (cm_addr !== ea || cm_wdata !== ed) begin
               bad++;
               $display("FAIL %s write: actual=%h:%h expected=%h:%h", t, cm_addr, cm_wdata, ea, ed);
            end
         end
      end
   end

   initial begin
      #3000000;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      cyc();
      chk("R11 reset reg", 32'(reg_rdata), 32'h0);
      chk("R11 reset we", 32'(cm_we), 32'h0);

      // R9: idle pass-through
      push(6'd5, 16'h1234, "R9");
      host_we = 1'b1; host_addr = 6'd5; host_wdata = 16'h1234;
      cyc();
      push(6'd63, 16'hBEEF, "R9");
      host_addr = 6'd63; host_wdata = 16'hBEEF;
      cyc();
      host_we = 1'b0;
      chk("R9 queue drained", 32'(q_addr.size()), 32'h0);

      // R1: go without arm
      wr_ctl(ctl(1'b0, 4'hA, 1'b1), 1'b0);
      chk("R1 stored", 32'(reg_rdata), 32'(ctl(1'b0, 4'hA, 1'b1)));
      idle(50); pulse_sync(); idle(50); pulse_sync(); idle(20);
      chk("R1 no completion", 32'(reg_rdata), 32'(ctl(1'b0, 4'hA, 1'b1)));

      // R2: go already set, arm now set -> no start
      wr_ctl(ctl(1'b1, 4'hC, 1'b1), 1'b0);
      idle(30); pulse_sync(); idle(30); pulse_sync(); idle(10);
      chk("R2 no start", 32'(reg_rdata), 32'(ctl(1'b1, 4'hC, 1'b1)));
      wr_ctl(ctl(1'b1, 4'hC, 1'b0), 1'b0);

      // R3/R4/R5/R10: full fill, sync in start cycle ignored
      push_fill(4'h9, DEPTH, "R4");
      wr_ctl(ctl(1'b1, 4'h9, 1'b1), 1'b1);
      chk("R3 reg after start", 32'(reg_rdata), 32'(ctl(1'b1, 4'h9, 1'b1)));
      idle(10);
      host_we = 1'b1; host_addr = 6'd7; host_wdata = 16'h0ABC; // R10
      idle(3);
      host_we = 1'b0;
      idle(80);
      pulse_sync();
      chk("R5 go after first sync", 32'(reg_rdata[0]), 32'h1);
      idle(260);
      chk("R4 all words written", 32'(q_addr.size()), 32'h0);
      chk("R5 go before second sync", 32'(reg_rdata[0]), 32'h1);
      pulse_sync();
      chk("R5 completion", 32'(reg_rdata), 32'(ctl(1'b1, 4'h9, 1'b0)));
      idle(20);

      // R6: abort by clearing go, 10 words written
      push_fill(4'h3, 10, "R6");
      wr_ctl(ctl(1'b1, 4'h3, 1'b1), 1'b0);
      idle(41);
      wr_ctl(ctl(1'b1, 4'h3, 1'b0), 1'b0);
      chk("R6 reg after go clear", 32'(reg_rdata), 32'(ctl(1'b1, 4'h3, 1'b0)));
      idle(100); pulse_sync(); idle(200); pulse_sync(); idle(10);
      chk("R6 count", 32'(q_addr.size()), 32'h0);

      // R6: abort by clearing arm
      push_fill(4'h6, 10, "R6");
      wr_ctl(ctl(1'b1, 4'h6, 1'b1), 1'b0);
      idle(41);
      wr_ctl(ctl(1'b0, 4'h6, 1'b1), 1'b0);
      chk("R6 reg after arm clear", 32'(reg_rdata), 32'(ctl(1'b0, 4'h6, 1'b1)));
      idle(100); pulse_sync(); idle(200); pulse_sync(); idle(10);
      chk("R6 arm abort stays", 32'(reg_rdata), 32'(ctl(1'b0, 4'h6, 1'b1)));
      wr_ctl(ctl(1'b0, 4'h6, 1'b0), 1'b0);

      // R7: other write aborts, new pattern never written
      push_fill(4'hC, 10, "R7");
      wr_ctl(ctl(1'b1, 4'hC, 1'b1), 1'b0);
      idle(41);
      wr_ctl(ctl(1'b1, 4'h5, 1'b1), 1'b0);
      chk("R7 reg", 32'(reg_rdata), 32'(ctl(1'b1, 4'h5, 1'b1)));
      idle(100); pulse_sync(); idle(200); pulse_sync(); idle(10);
      chk("R7 go kept", 32'(reg_rdata), 32'(ctl(1'b1, 4'h5, 1'b1)));
      wr_ctl(ctl(1'b1, 4'h5, 1'b0), 1'b0);

      // R8: write in the completing sync cycle wins
      push_fill(4'h7, DEPTH, "R8");
      wr_ctl(ctl(1'b1, 4'h7, 1'b1), 1'b0);
      idle(20); pulse_sync(); idle(280);
      chk("R8 sweep done", 32'(q_addr.size()), 32'h0);
      wr_ctl(ctl(1'b1, 4'h2, 1'b1), 1'b1);
      chk("R8 write wins", 32'(reg_rdata), 32'(ctl(1'b1, 4'h2, 1'b1)));
      idle(100); pulse_sync(); idle(200); pulse_sync(); idle(10);
      chk("R8 no new fill", 32'(reg_rdata), 32'(ctl(1'b1, 4'h2, 1'b1)));

      chk("scoreboard empty", 32'(q_addr.size()), 32'h0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule